// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes serial PCM audio arriving on several data lines that share one bit clock and one frame clock. It recovers a left and a right sample from every line in each frame, so four lines carry eight channels. A 3-bit format code chooses the framing at run time. Code 0 is left-justified and code 1 is I2S. Codes 2 to 5 are right-justified, with 16, 24, 20 or 18 bits placed at the end of each half-frame. Each sample is widened to 24 bits. When a half-frame ends, the samples from all lines are presented together with a left/right tag and a valid pulse.

The serial pins are brought into the system clock domain through a multi-stage synchronizer. The bit clock is oversampled, and each rising edge of the bit clock is a bit strobe. On each strobe the frame clock level and one bit per line are taken. A change in the frame clock level closes the half-frame that was in progress. The bits of that half-frame are then decoded under the format code that was in force when the half-frame began, and the result is loaded into the output registers.

Top module: `sar_rx`

## Requirements
- R1: While `rst` is high at a clock edge, `valid_o`, `chan_o` and every bit of `sample_o` are 0 after that edge.
- R2: On each rising edge of `bclk_i`, `lrck_i` and one bit of each `sdata_i` line are sampled. A sampled `lrck_i` that differs from the previous sample closes a half-frame. `valid_o` then pulses for one clock, exactly SYNC_STAGES+1 clock cycles after the `bclk_i` rise on which the change was seen. The first change after reset produces no pulse, and every later change produces exactly one.
- R3: Code 0 (left-justified): the bit sampled k bit clocks after the frame edge (k=0 on the edge) lands in sample bit 23-k, for k from 0 to 23. Bits with k of 24 or more are ignored. If the half-frame has fewer than 24 bits, the unfilled low bits are 0.
- R4: Code 1 (I2S): the same as R3, but data bit 23-j is taken at k=j+1. The bit taken at k=0 is ignored.
- R5: Codes 2, 3, 4 and 5 (right-justified, N = 16, 24, 20, 18): the last N bits of the half-frame form the sample, with the last bit as the LSB. The sample is sign-extended from bit N-1 to 24 bits, and earlier bits are ignored. If the half-frame has fewer than N bits, the missing leading bits count as 0.
- R6: `chan_o` tags the half-frame just completed: 0 for left, 1 for right. Under code 1, a low frame clock is left. Under every other code, a high frame clock is left.
- R7: A change of `fmt_i` takes effect at the next frame clock change. A half-frame is decoded and tagged with the code sampled on its opening edge, even if `fmt_i` changes partway through.
- R8: Each line is decoded on its own. Line i appears on `sample_o[24*i+23 : 24*i]`.
- R9: Codes 6 and 7 behave exactly as code 0, including the tag polarity.
- R10: `sample_o` and `chan_o` change only on the clock at which `valid_o` is high, and hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run several times faster than `bclk_i` |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i | input | 3 | Framing code (0 left-justified, 1 I2S, 2..5 right-justified 16/24/20/18, 6/7 as 0) |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| lrck_i | input | 1 | Frame (left/right) clock, asynchronous |
| sdata_i | input | LANES | Serial data lines, MSB first, two's complement |
| sample_o | output | LANES*24 | Recovered samples, line i at bits 24*i+23..24*i |
| chan_o | output | 1 | Tag of the presented samples: 0 left, 1 right |
| valid_o | output | 1 | One-clock strobe marking new samples |

## Verification
Results are due SYNC_STAGES+1 system clock cycles after the `bclk_i` rise that first shows a changed `lrck_i`. That is three cycles with the default synchronizer depth. The bench drives every pin on the falling clock edge and notes the posedge count at the rise that opens each half-frame. It samples outputs only on falling edges, and each observed `valid_o` pulse must fall exactly that many cycles after the noted rise. A queue of expected results is filled from a bench model as each half-frame is driven and emptied by the pulses. In the middle of each following half-frame, the bench checks that the outputs still hold the last result.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int SAMPLE_W = 24;
  localparam int FMT_W    = 3;

  typedef enum logic [1:0] {K_LJ, K_I2S, K_RJ} fkind_t;

  function automatic fkind_t fmt_kind(input logic [FMT_W-1:0] f);
    case (f)
      3'd1:                 return K_I2S;
      3'd2, 3'd3, 3'd4, 3'd5: return K_RJ;
      default:              return K_LJ;
    endcase
  endfunction

  function automatic int rj_len(input logic [FMT_W-1:0] f);
    case (f)
      3'd2:    return 16;
      3'd4:    return 20;
      3'd5:    return 18;
      default: return 24;
    endcase
  endfunction

  // keep the low n bits, replicate bit n-1 upward
  function automatic logic [SAMPLE_W-1:0] sext(input logic [SAMPLE_W-1:0] v, input int n);
    logic signed [SAMPLE_W-1:0] t;
    int s;
    s = SAMPLE_W - n;
    t = v << s;
    t = t >>> s;
    return t;
  endfunction
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) q[i] <= '0;
    end else begin
      q[0] <= din;
      for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
    end
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/sar_frame_ctl.sv
module sar_frame_ctl import sar_pkg::*; #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_s,
  input  logic             lrck_s,
  input  logic [FMT_W-1:0] fmt_i,
  output logic             bit_stb,
  output logic             edge_stb,
  output logic             fire,
  output logic [CNT_W-1:0] idx,
  output logic [FMT_W-1:0] fmt_cur,
  output logic [FMT_W-1:0] fmt_act,
  output logic             done_right
);
  logic             bclk_d;
  logic             lr_prev;
  logic             primed;
  logic             started;
  logic [CNT_W-1:0] cnt;
  logic [FMT_W-1:0] fmt_q;

  assign bit_stb    = bclk_s & ~bclk_d;
  assign edge_stb   = bit_stb & primed & (lrck_s ^ lr_prev);
  assign fire       = edge_stb & started;
  assign idx        = edge_stb ? '0 : cnt;
  assign fmt_cur    = edge_stb ? fmt_i : fmt_q;
  assign fmt_act    = fmt_q;
  assign done_right = (fmt_kind(fmt_q) == K_I2S) ? lr_prev : ~lr_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_d  <= 1'b0;
      lr_prev <= 1'b0;
      primed  <= 1'b0;
      started <= 1'b0;
      cnt     <= '0;
      fmt_q   <= '0;
    end else begin
      bclk_d <= bclk_s;
      if (bit_stb) begin
        primed  <= 1'b1;
        lr_prev <= lrck_s;
        if (edge_stb) begin
          started <= 1'b1;
          fmt_q   <= fmt_i;
          cnt     <= CNT_W'(1);
        end else if (cnt != '1) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sar_lane.sv
module sar_lane import sar_pkg::*; #(
  parameter int CNT_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_stb,
  input  logic                edge_stb,
  input  logic                din,
  input  logic [CNT_W-1:0]    idx,
  input  logic [FMT_W-1:0]    fmt_cur,
  input  logic [FMT_W-1:0]    fmt_done,
  output logic [SAMPLE_W-1:0] word
);
  localparam int PW = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0] sh;
  logic [SAMPLE_W-1:0] sh_nxt;
  logic [SAMPLE_W-1:0] base;

  always_comb begin
    base   = edge_stb ? '0 : sh;
    sh_nxt = base;
    case (fmt_kind(fmt_cur))
      K_LJ: begin
        if (int'(idx) < SAMPLE_W) sh_nxt[PW'(SAMPLE_W - 1 - int'(idx))] = din;
      end
      K_I2S: begin
        if (idx != '0 && int'(idx) <= SAMPLE_W) sh_nxt[PW'(SAMPLE_W - int'(idx))] = din;
      end
      default: sh_nxt = {base[SAMPLE_W-2:0], din};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          sh <= '0;
    else if (bit_stb) sh <= sh_nxt;
  end

  always_comb begin
    if (fmt_kind(fmt_done) == K_RJ) word = sext(sh, rj_len(fmt_done));
    else                            word = sh;
  end
endmodule

// File: rtl/sar_out_reg.sv
module sar_out_reg import sar_pkg::*; #(
  parameter int LANES = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fire,
  input  logic                      right,
  input  logic [LANES*SAMPLE_W-1:0] words,
  output logic [LANES*SAMPLE_W-1:0] sample_o,
  output logic                      chan_o,
  output logic                      valid_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o <= '0;
      chan_o   <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= fire;
      if (fire) begin
        sample_o <= words;
        chan_o   <= right;
      end
    end
  end
endmodule

// File: rtl/sar_rx.sv
module sar_rx import sar_pkg::*; #(
  parameter int LANES       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [FMT_W-1:0]          fmt_i,
  input  logic                      bclk_i,
  input  logic                      lrck_i,
  input  logic [LANES-1:0]          sdata_i,
  output logic [LANES*SAMPLE_W-1:0] sample_o,
  output logic                      chan_o,
  output logic                      valid_o
);
  localparam int CNT_W = $clog2(SAMPLE_W + 2);

  logic [LANES+1:0]          pins_s;
  logic                      bclk_s;
  logic                      lrck_s;
  logic [LANES-1:0]          sdata_s;
  logic                      bit_stb;
  logic                      edge_stb;
  logic                      fire;
  logic [CNT_W-1:0]          idx;
  logic [FMT_W-1:0]          fmt_cur;
  logic [FMT_W-1:0]          fmt_act;
  logic                      done_right;
  logic [LANES*SAMPLE_W-1:0] words;

  sar_sync #(.W(LANES + 2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({lrck_i, bclk_i, sdata_i}),
    .dout (pins_s)
  );

  assign sdata_s = pins_s[LANES-1:0];
  assign bclk_s  = pins_s[LANES];
  assign lrck_s  = pins_s[LANES+1];

  sar_frame_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .bclk_s     (bclk_s),
    .lrck_s     (lrck_s),
    .fmt_i      (fmt_i),
    .bit_stb    (bit_stb),
    .edge_stb   (edge_stb),
    .fire       (fire),
    .idx        (idx),
    .fmt_cur    (fmt_cur),
    .fmt_act    (fmt_act),
    .done_right (done_right)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sar_lane #(.CNT_W(CNT_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .bit_stb  (bit_stb),
      .edge_stb (edge_stb),
      .din      (sdata_s[l]),
      .idx      (idx),
      .fmt_cur  (fmt_cur),
      .fmt_done (fmt_act),
      .word     (words[l*SAMPLE_W +: SAMPLE_W])
    );
  end

  sar_out_reg #(.LANES(LANES)) u_out (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .right    (done_right),
    .words    (words),
    .sample_o (sample_o),
    .chan_o   (chan_o),
    .valid_o  (valid_o)
  );
endmodule

// File: rtl/sar_rx_chk.sv
module sar_rx_chk import sar_pkg::*; #(
  parameter int LANES = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      valid_o,
  input logic                      chan_o,
  input logic [LANES*SAMPLE_W-1:0] sample_o,
  input logic                      edge_stb,
  input logic [FMT_W-1:0]          fmt_act
);
  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!valid_o && !chan_o && sample_o == '0));

  // R2
  one_cycle_valid_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R2
  valid_after_edge_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(edge_stb));

  // R10
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(sample_o) && $stable(chan_o)));

  // R7
  fmt_at_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !edge_stb |=> $stable(fmt_act));
endmodule

bind sar_rx sar_rx_chk #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .valid_o  (valid_o),
  .chan_o   (chan_o),
  .sample_o (sample_o),
  .edge_stb (edge_stb),
  .fmt_act  (fmt_act)
);

// File: tb/sar_rx_test.sv
module sar_rx_test;
  import sar_pkg::*;

  localparam int LANES = 4;
  localparam int SYNC  = 2;
  localparam int HALF  = 4;
  localparam int SW    = 24;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                rst;
  logic [2:0]          fmt_i;
  logic                bclk_i;
  logic                lrck_i;
  logic [LANES-1:0]    sdata_i;
  logic [LANES*SW-1:0] sample_o;
  logic                chan_o;
  logic                valid_o;

  sar_rx #(.LANES(LANES), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst(rst), .fmt_i(fmt_i), .bclk_i(bclk_i), .lrck_i(lrck_i),
    .sdata_i(sdata_i), .sample_o(sample_o), .chan_o(chan_o), .valid_o(valid_o)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int edge_cyc = 0;
  bit done = 0;
  bit have_obs = 0;
  logic prev_lr = 1'b0;
  logic [LANES*SW-1:0] last_s;
  logic last_c;
  string ovr = "";
  logic [63:0] w [LANES];

  logic [LANES*SW-1:0] q_s [$];
  logic                q_c [$];
  string               q_l [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [2:0] norm(input logic [2:0] f);
    return (f > 3'd5) ? 3'd0 : f;
  endfunction

  function automatic string req_of(input logic [2:0] f);
    if (f > 3'd5) return "R9";
    if (f == 3'd0) return "R3";
    if (f == 3'd1) return "R4";
    return "R5";
  endfunction

  // bench model: bit k of a half-frame of n bits is w[n-1-k]
  function automatic logic [SW-1:0] model(input logic [2:0] fin, input int n, input logic [63:0] v);
    logic [SW-1:0] r;
    logic [2:0] f;
    int off;
    int len;
    logic top;
    r = '0;
    f = norm(fin);
    if (f <= 3'd1) begin
      off = (f == 3'd1) ? 1 : 0;
      for (int j = 0; j < SW; j++)
        if (j + off < n) r[SW-1-j] = v[n-1-j-off];
    end else begin
      case (f)
        3'd2: len = 16;
        3'd4: len = 20;
        3'd5: len = 18;
        default: len = 24;
      endcase
      top = (len - 1 < n) ? v[len-1] : 1'b0;
      for (int i = 0; i < SW; i++)
        r[i] = (i < len) ? ((i < n) ? v[i] : 1'b0) : top;
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst === 1'b0 && valid_o === 1'b1) begin
      if (q_s.size() == 0) begin
        chk(1'b0, "R2", 64'd1, 64'd0);
      end else begin
        logic [LANES*SW-1:0] es;
        logic ec;
        string el;
        es = q_s.pop_front();
        ec = q_c.pop_front();
        el = q_l.pop_front();
        chk(cyc - edge_cyc == SYNC + 1, "R2", 64'(cyc - edge_cyc), 64'(SYNC + 1));
        chk(chan_o == ec, "R6", 64'(chan_o), 64'(ec));
        for (int l = 0; l < LANES; l++)
          chk(sample_o[l*SW +: SW] == es[l*SW +: SW], el,
              64'(sample_o[l*SW +: SW]), 64'(es[l*SW +: SW]));
      end
      last_s = sample_o;
      last_c = chan_o;
      have_obs = 1;
    end
  end

  task automatic send_half(input logic lr, input int n, input bit expo,
                           input int chg_k, input logic [2:0] chg_f);
    logic [2:0] f0;
    logic [LANES*SW-1:0] es;
    f0 = fmt_i;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bclk_i = 1'b0;
      lrck_i = lr;
      for (int l = 0; l < LANES; l++) sdata_i[l] = w[l][n-1-k];
      if (k == chg_k) fmt_i = chg_f;
      repeat (HALF - 1) @(negedge clk);
      @(negedge clk);
      bclk_i = 1'b1;
      if (k == 0 && lr != prev_lr) edge_cyc = cyc;
      repeat (HALF - 1) @(negedge clk);
      if (k == n / 2 && have_obs) begin
        for (int l = 0; l < LANES; l++)
          chk(sample_o[l*SW +: SW] == last_s[l*SW +: SW], "R10",
              64'(sample_o[l*SW +: SW]), 64'(last_s[l*SW +: SW]));
        chk(chan_o == last_c, "R10", 64'(chan_o), 64'(last_c));
      end
    end
    prev_lr = lr;
    if (expo) begin
      for (int l = 0; l < LANES; l++) es[l*SW +: SW] = model(f0, n, w[l]);
      q_s.push_back(es);
      q_c.push_back((norm(f0) == 3'd1) ? lr : ~lr);
      q_l.push_back((ovr != "") ? ovr : req_of(f0));
    end
  endtask

  task automatic rnd_w();
    for (int l = 0; l < LANES; l++) w[l] = {$urandom, $urandom};
  endtask

  task automatic hf(input int n);
    send_half(~prev_lr, n, 1'b1, -1, 3'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd77);
    rst = 1'b1; fmt_i = 3'd0; bclk_i = 1'b0; lrck_i = 1'b0; sdata_i = '0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(valid_o == 1'b0, "R1", 64'(valid_o), 64'd0);
    chk(chan_o == 1'b0, "R1", 64'(chan_o), 64'd0);
    chk(sample_o == '0, "R1", 64'(sample_o[63:0]), 64'd0);
    rst = 1'b0;

    rnd_w();
    send_half(1'b0, 8, 1'b0, -1, 3'd0);   // prime, no result
    // left-justified: exact, long (R3 ignore tail), short (zero pad)
    rnd_w(); hf(24); rnd_w(); hf(32); rnd_w(); hf(16);
    // I2S
    fmt_i = 3'd1;
    rnd_w(); hf(25); rnd_w(); hf(32); rnd_w(); hf(17);
    // right-justified word lengths
    for (int f = 2; f <= 5; f++) begin
      int len;
      fmt_i = 3'(f);
      len = (f == 2) ? 16 : (f == 3) ? 24 : (f == 4) ? 20 : 18;
      rnd_w(); hf(len);
      rnd_w(); hf(32);
      rnd_w(); w[0][len-1] = 1'b1; w[1][len-1] = 1'b0; hf(len);
    end
    // R7: code change in mid half-frame applies from the next edge
    fmt_i = 3'd3; ovr = "R7";
    rnd_w(); send_half(~prev_lr, 24, 1'b1, 5, 3'd0);
    rnd_w(); hf(24);
    // R8: independent lanes
    fmt_i = 3'd3; ovr = "R8";
    w[0] = '1; w[1] = '0; w[2] = 64'h800000; w[3] = 64'h00A5A5;
    hf(24);
    ovr = "";
    // R9: reserved codes
    fmt_i = 3'd6; rnd_w(); hf(20); rnd_w(); hf(30);
    fmt_i = 3'd7; rnd_w(); hf(24); rnd_w(); hf(28);
    // constrained random
    for (int i = 0; i < 40; i++) begin
      fmt_i = 3'($urandom_range(7, 0));
      rnd_w();
      hf(16 + int'($urandom_range(16, 0)));
    end
    // flush the last half-frame
    rnd_w();
    send_half(~prev_lr, 4, 1'b0, -1, 3'd0);
    repeat (20) @(negedge clk);
    chk(q_s.size() == 0, "R2", 64'(q_s.size()), 64'd0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule